// File: doc/BRIEF.md
# Link-side transmit handshake controller

This block sits on the link side of a split physical/link interface and runs the link's half of a transmit. A link core pulses a transmit request. The block raises its request line and waits for the physical side to grant the shared bus. It then takes over the shared control pair (CTL) and the data symbols (D). It streams one or more packets from a valid/ready input and finally hands both signal groups back in high impedance. Only this handshake is modelled. Cable arbitration and any serial encoding of the request line are outside the block.

The control pair carries four codes. The link drives 00 for idle, 01 for hold and 10 for transmit. The physical side grants the bus by driving 11 for one cycle and then idle for one cycle. The block keeps a registered copy of CTL. Because of that copy, the link starts driving in the cycle after the physical side's idle cycle, and never while the physical side is still driving. All outputs are registered. Whenever the link drives, D is zero except in transmit cycles.

The packet stream uses valid/ready. A beat moves on a cycle where `pkt_valid` and `pkt_ready` are both high. The producer must hold a beat and its side flags stable while ready is low. Ready is high only while the link owns the bus, or is taking it over in the current cycle. Inside a packet, valid must not drop between the first and the last beat. `pkt_more` is sampled with the last beat and says whether another packet follows in the same bus ownership.

Top module: `lnk_tx_ctrl`

## Requirements
- R1: While reset is low and right after it, `phy_req` is 0, `ctl_oe` and `d_oe` are 0, and `pkt_ready` is 0.
- R2: A `tx_start` pulse seen while the block is idle raises `phy_req` from the next cycle. `phy_req` stays high until the grant has been taken.
- R3: A grant is CTL input 11 for one cycle. The link never drives CTL or D during the grant cycle or the cycle after it. It drives in the cycle after those two, and `phy_req` is low from that same cycle.
- R4: If no beat is offered when the link takes the bus, it drives hold (01) with D at zero until the first beat is accepted.
- R5: If a beat is already offered when the link takes the bus, the first driven cycle is transmit (10) carrying that beat, with no hold before it.
- R6: Each accepted beat appears on D with CTL at 10 in the next cycle, in order. `pkt_ready` is 0 while the bus is released and no grant is being taken.
- R7: The cycle after a packet's last symbol carries hold (01) when `pkt_more` was 1 with the last beat, and idle (00) otherwise.
- R8: That cycle is followed by exactly one idle (00) cycle, after which `ctl_oe` and `d_oe` drop together.
- R9: After a hold-ended packet, the link does not raise `phy_req`. It waits for a new 11 grant with the same two-cycle turnaround before it drives again, and `pkt_ready` stays 0 meanwhile.
- R10: `tx_start` is ignored outside the idle state, so no new request is issued until the release has completed. `phy_req` is never high while the link drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Transmit request pulse from the link core |
| pkt_valid | input | 1 | Packet beat offered |
| pkt_data | input | DW | Packet data symbol |
| pkt_last | input | 1 | Beat is the last of its packet |
| pkt_more | input | 1 | With the last beat: another packet follows in this ownership |
| pkt_ready | output | 1 | Beat is accepted this cycle if valid |
| phy_req | output | 1 | Bus request toward the physical side |
| ctl_in | input | 2 | CTL as driven by the physical side |
| ctl_out | output | 2 | CTL driven by the link |
| ctl_oe | output | 1 | Output enable for CTL |
| d_out | output | DW | D driven by the link |
| d_oe | output | 1 | Output enable for D |

## Verification
The bench targets the grant turnaround. A design that drove one cycle early would collide with the physical side's idle cycle. The first driven code is checked both with data preloaded and with data arriving late, which catches a design that always holds first or that sends before data exists. The tail is matched symbol by symbol, including a one-beat packet and a chain of three packets joined by hold markers. A design with a missing idle cycle, a wrong marker or an early tristate breaks that sequence. A request pulse given during ownership must not produce a second request, and a block that latched it would show `phy_req` rising after release.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
  localparam int CTL_W = 2;
  typedef logic [CTL_W-1:0] ctl_t;

  localparam ctl_t CTL_IDLE  = 2'b00;
  localparam ctl_t CTL_HOLD  = 2'b01;
  localparam ctl_t CTL_XMIT  = 2'b10;
  localparam ctl_t CTL_GRANT = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,   // bus released, accepting a new start
    ST_REQ,    // request raised, waiting for grant
    ST_OWN,    // link owns bus: hold or streaming
    ST_LAST,   // last symbol is on the bus
    ST_MARK,   // end marker (hold or idle) on the bus
    ST_IDL2,   // trailing idle on the bus
    ST_WAITG   // released after hold marker, waiting regrant
  } st_e;
endpackage

// File: rtl/lnk_tx_sampler.sv
module lnk_tx_sampler
  import lnk_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t ctl_in,
  output logic grant_seen
);
  ctl_t ctl_r;

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_r <= CTL_IDLE;
    else        ctl_r <= ctl_in;
  end

  assign grant_seen = (ctl_r == CTL_GRANT);
endmodule

// File: rtl/lnk_tx_fsm.sv
module lnk_tx_fsm
  import lnk_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_start,
  input  logic grant_seen,
  input  logic pkt_valid,
  input  logic pkt_last,
  input  logic pkt_more,
  output logic pkt_ready,
  output logic nxt_oe,
  output ctl_t nxt_ctl,
  output logic nxt_load,
  output logic nxt_req
);
  st_e  st_q, st_d;
  logic more_q, more_d;
  logic take;

  assign take = pkt_valid && pkt_ready;

  always_comb begin
    st_d      = st_q;
    more_d    = more_q;
    pkt_ready = 1'b0;
    nxt_oe    = 1'b0;
    nxt_ctl   = CTL_IDLE;
    nxt_load  = 1'b0;
    nxt_req   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tx_start) begin
          st_d    = ST_REQ;
          nxt_req = 1'b1;
        end
      end
      ST_REQ, ST_WAITG, ST_OWN: begin
        nxt_req = (st_q == ST_REQ) && !grant_seen;
        if (st_q == ST_OWN || grant_seen) begin
          pkt_ready = 1'b1;
          nxt_oe    = 1'b1;
          if (take) begin
            nxt_ctl  = CTL_XMIT;
            nxt_load = 1'b1;
            if (pkt_last) begin
              more_d = pkt_more;
              st_d   = ST_LAST;
            end else begin
              st_d   = ST_OWN;
            end
          end else begin
            nxt_ctl = CTL_HOLD;
            st_d    = ST_OWN;
          end
        end
      end
      ST_LAST: begin
        nxt_oe  = 1'b1;
        nxt_ctl = more_q ? CTL_HOLD : CTL_IDLE;
        st_d    = ST_MARK;
      end
      ST_MARK: begin
        nxt_oe  = 1'b1;
        nxt_ctl = CTL_IDLE;
        st_d    = ST_IDL2;
      end
      ST_IDL2: begin
        st_d = more_q ? ST_WAITG : ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      more_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      more_q <= more_d;
    end
  end
endmodule

// File: rtl/lnk_tx_drive.sv
module lnk_tx_drive
  import lnk_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nxt_oe,
  input  ctl_t          nxt_ctl,
  input  logic          nxt_load,
  input  logic          nxt_req,
  input  logic [DW-1:0] pkt_data,
  output ctl_t          ctl_out,
  output logic          ctl_oe,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  output logic          phy_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_out <= CTL_IDLE;
      ctl_oe  <= 1'b0;
      d_out   <= '0;
      d_oe    <= 1'b0;
      phy_req <= 1'b0;
    end else begin
      ctl_out <= nxt_ctl;
      ctl_oe  <= nxt_oe;
      d_out   <= nxt_load ? pkt_data : '0;
      d_oe    <= nxt_oe;
      phy_req <= nxt_req;
    end
  end
endmodule

// File: rtl/lnk_tx_ctrl.sv
module lnk_tx_ctrl
  import lnk_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic          pkt_valid,
  input  logic [DW-1:0] pkt_data,
  input  logic          pkt_last,
  input  logic          pkt_more,
  output logic          pkt_ready,
  output logic          phy_req,
  input  logic [1:0]    ctl_in,
  output logic [1:0]    ctl_out,
  output logic          ctl_oe,
  output logic [DW-1:0] d_out,
  output logic          d_oe
);
  logic grant_seen;
  logic nxt_oe, nxt_load, nxt_req;
  ctl_t nxt_ctl;

  lnk_tx_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .grant_seen(grant_seen)
  );

  lnk_tx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .grant_seen(grant_seen),
    .pkt_valid(pkt_valid), .pkt_last(pkt_last), .pkt_more(pkt_more),
    .pkt_ready(pkt_ready), .nxt_oe(nxt_oe), .nxt_ctl(nxt_ctl),
    .nxt_load(nxt_load), .nxt_req(nxt_req)
  );

  lnk_tx_drive #(.DW(DW)) u_drv (
    .clk(clk), .rst_n(rst_n), .nxt_oe(nxt_oe), .nxt_ctl(nxt_ctl),
    .nxt_load(nxt_load), .nxt_req(nxt_req), .pkt_data(pkt_data),
    .ctl_out(ctl_out), .ctl_oe(ctl_oe), .d_out(d_out), .d_oe(d_oe),
    .phy_req(phy_req)
  );
endmodule

// File: rtl/lnk_tx_ctrl_chk.sv
module lnk_tx_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pkt_valid,
  input logic [DW-1:0] pkt_data,
  input logic          pkt_ready,
  input logic          phy_req,
  input logic [1:0]    ctl_in,
  input logic [1:0]    ctl_out,
  input logic          ctl_oe,
  input logic [DW-1:0] d_out,
  input logic          d_oe
);
  p_no_drive_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_in == 2'b11) |-> !ctl_oe && !d_oe);

  p_no_drive_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_in == 2'b11) |-> !ctl_oe && !d_oe);

  p_d_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && ctl_out != 2'b10) |-> (d_out == '0));

  p_beat_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> (ctl_oe && ctl_out == 2'b10 && d_out == $past(pkt_data)));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> ($past(ctl_out) == 2'b00) && !d_oe);

  p_ready_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_oe && !$past(ctl_in == 2'b11)) |-> !pkt_ready);

  p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |-> !phy_req);
endmodule

bind lnk_tx_ctrl lnk_tx_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
  .pkt_ready(pkt_ready), .phy_req(phy_req), .ctl_in(ctl_in),
  .ctl_out(ctl_out), .ctl_oe(ctl_oe), .d_out(d_out), .d_oe(d_oe)
);

// File: tb/lnk_tx_ctrl_bench.sv
module lnk_tx_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam logic [1:0] C_IDLE = 2'b00, C_HOLD = 2'b01, C_XMIT = 2'b10, C_GRANT = 2'b11;
  localparam logic [3:0] T_D = 4'd1, T_MH = 4'd2, T_MI = 4'd3, T_IDL = 4'd4, T_Z = 4'd5, T_BAD = 4'd15;

  logic clk = 0, rst_n = 0;
  logic tx_start = 0, pkt_valid = 0, pkt_last = 0, pkt_more = 0;
  logic [DW-1:0] pkt_data = '0;
  logic [1:0] ctl_in = C_IDLE;
  logic pkt_ready, phy_req, ctl_oe, d_oe;
  logic [1:0] ctl_out;
  logic [DW-1:0] d_out;

  int checks = 0, failures = 0;
  int grant_cnt = 0;
  logic [1:0] exp_first = C_XMIT;
  logic mark_hold = 0;
  logic [DW+3:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_tx_ctrl #(.DW(DW)) u_lnk_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .pkt_valid(pkt_valid),
    .pkt_data(pkt_data), .pkt_last(pkt_last), .pkt_more(pkt_more),
    .pkt_ready(pkt_ready), .phy_req(phy_req), .ctl_in(ctl_in),
    .ctl_out(ctl_out), .ctl_oe(ctl_oe), .d_out(d_out), .d_oe(d_oe)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // physical-side grant: 11 for one cycle, 00 for one cycle, link drives after
  task automatic do_grant(input bit first);
    @(negedge clk);
    ctl_in = C_GRANT;
    check(pkt_ready == 0, "R6 ready low before grant registered", pkt_ready, 0);
    @(negedge clk);
    ctl_in = C_IDLE;
    check(ctl_oe == 0 && d_oe == 0, "R3 no drive in turnaround", ctl_oe, 0);
    if (first) check(phy_req == 1, "R2 request held until grant", phy_req, 1);
    else       check(phy_req == 0, "R9 no request on regrant", phy_req, 0);
    @(negedge clk);
    check(ctl_oe == 1 && d_oe == 1, "R3 drive after turnaround", ctl_oe, 1);
    check(phy_req == 0, "R3 request dropped at takeover", phy_req, 0);
    check(ctl_out == exp_first, (exp_first == C_HOLD) ? "R4 first code hold" : "R5 first code transmit",
          ctl_out, exp_first);
    grant_cnt++;
  endtask

  initial begin : phy
    @(posedge rst_n);
    forever begin
      do @(negedge clk); while (!phy_req);
      repeat (2) @(negedge clk);
      do_grant(1'b1);
      forever begin
        do @(negedge clk); while (ctl_oe);
        if (!mark_hold) break;
        repeat (3) @(negedge clk);
        check(pkt_ready == 0, "R9 ready low while waiting regrant", pkt_ready, 0);
        do_grant(1'b0);
      end
    end
  end

  initial begin : mon
    int tail;
    logic [DW+3:0] tok, e;
    bit have;
    tail = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      have = 0;
      tok = '0;
      if (ctl_oe && d_oe && ctl_out == C_XMIT) begin
        tok = {T_D, d_out}; have = 1; tail = 1;
      end else if (tail == 1) begin
        have = 1; tail = 2;
        if (ctl_oe && ctl_out == C_HOLD && d_out == 0) begin tok = {T_MH, 8'h00}; mark_hold = 1; end
        else if (ctl_oe && ctl_out == C_IDLE && d_out == 0) begin tok = {T_MI, 8'h00}; mark_hold = 0; end
        else tok = {T_BAD, 6'h0, ctl_out};
      end else if (tail == 2) begin
        have = 1; tail = 3;
        tok = (ctl_oe && d_oe && ctl_out == C_IDLE) ? {T_IDL, 8'h00} : {T_BAD, 6'h0, ctl_out};
      end else if (tail == 3) begin
        have = 1; tail = 0;
        tok = (!ctl_oe && !d_oe) ? {T_Z, 8'h00} : {T_BAD, 8'h01};
      end else if (ctl_oe) begin
        check(ctl_out == C_HOLD && d_out == 0, "R4 hold with zero D before data", {ctl_out, d_out}, {C_HOLD, 8'h00});
      end
      if (have) begin
        if (expq.size() == 0) begin
          check(0, "R6 unexpected symbol", tok, 0);
        end else begin
          e = expq.pop_front();
          check(tok == e, (e[DW+3:DW] == T_D) ? "R6 data symbol" :
                          (e[DW+3:DW] == T_MH || e[DW+3:DW] == T_MI) ? "R7 end marker" :
                          "R8 idle then release", tok, e);
        end
      end
    end
  end

  task automatic send_pkt(input int len, input bit more, input bit late, input logic [DW-1:0] base);
    int tgt;
    tgt = grant_cnt + 1;
    exp_first = late ? C_HOLD : C_XMIT;
    if (late) begin
      while (grant_cnt < tgt) @(negedge clk);
      repeat (2) @(negedge clk);
    end
    for (int i = 0; i < len; i++) begin
      pkt_valid = 1;
      pkt_data  = base + DW'(i);
      pkt_last  = (i == len - 1);
      pkt_more  = more;
      expq.push_back({T_D, base + DW'(i)});
      if (i == len - 1) begin
        expq.push_back({more ? T_MH : T_MI, 8'h00});
        expq.push_back({T_IDL, 8'h00});
        expq.push_back({T_Z, 8'h00});
      end
      forever begin
        if (pkt_ready) begin @(negedge clk); break; end
        @(negedge clk);
      end
    end
    pkt_valid = 0; pkt_last = 0; pkt_more = 0;
  endtask

  task automatic start_pulse();
    tx_start = 1;
    @(negedge clk);
    tx_start = 0;
    @(negedge clk);
    check(phy_req == 1, "R2 request raised after start", phy_req, 1);
  endtask

  task automatic settle();
    while (expq.size() != 0) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(phy_req == 0 && ctl_oe == 0, "R10 no stray request after release", {phy_req, ctl_oe}, 0);
    end
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(phy_req == 0 && ctl_oe == 0 && d_oe == 0 && pkt_ready == 0, "R1 reset state",
          {phy_req, ctl_oe, d_oe, pkt_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    check(phy_req == 0 && ctl_oe == 0 && pkt_ready == 0, "R1 after reset", {phy_req, ctl_oe, pkt_ready}, 0);

    // single packet, data preloaded before grant (R5)
    pkt_valid = 1; pkt_data = 8'h10; pkt_last = 0;
    fork
      start_pulse();
      send_pkt(4, 0, 0, 8'h10);
    join
    settle();

    // single packet, data arrives after takeover (R4)
    fork
      start_pulse();
      send_pkt(3, 0, 1, 8'h40);
    join
    settle();

    // three packets under one ownership, single-beat last packet; stray start ignored (R9, R10)
    fork
      start_pulse();
      begin
        send_pkt(2, 1, 0, 8'h70);
        send_pkt(5, 1, 1, 8'h80);
        send_pkt(1, 0, 0, 8'hC5);
      end
      begin
        while (!ctl_oe) @(negedge clk);
        tx_start = 1;
        @(negedge clk);
        tx_start = 0;
        check(phy_req == 0, "R10 start during ownership ignored", phy_req, 0);
      end
    join
    settle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule